// File: doc/BRIEF.md
# DMA Status and Interrupt Register Bank

This block holds the status seen by software for a pair of packet DMA engines, one that transmits and one that receives. Each engine reports events as single-cycle pulses. Transmit reports a packet sent or an underrun. Receive reports a packet stored or an overflow. The bank counts completed packets in per-direction 8-bit counters and keeps a packet flag and an error flag for each direction. It also holds the receive DMA enable bit, which the engine reads back.

Software accesses the bank through a simple 32-bit word-indexed port, with single-cycle writes and combinational reads. Writing a one to bit 0 of a status register acknowledges one packet: it lowers the count by one. The packet flag drops only when the count returns to zero. The bank combines the low status nibbles with an 8-bit mask to form an interrupt status byte. A single interrupt line is registered from that byte.

Top module: `dma_stat_irq_regs`

## Requirements
- R1: After reset, every register (word indexes 0 to 4) reads zero, `rx_dma_en` is low and `irq` is low.
- R2: The register map uses word indexes as follows. Index 0 is transmit status: count in bits [23:16], underrun in bit 1, packet-sent in bit 0. Index 1 is receive status: count in bits [23:16], overflow in bit 2, packet-received in bit 0. Index 2 is receive control: enable in bit 0. Index 3 is the interrupt mask, bits [7:0]. Index 4 is interrupt status, bits [7:0]. Unused bits and unused indexes read zero.
- R3: A packet event (`ev_tx_sent` or `ev_rx_rcvd`) raises the matching count by one and sets the matching packet flag on the next clock edge.
- R4: A write of bit 0 = 1 to a status register lowers that register's count by one. The packet flag clears only when the resulting count is 0; otherwise the flag is unchanged.
- R5: Writing 1 to transmit-status bit 1 clears underrun, and writing 1 to receive-status bit 2 clears overflow. Writing 0 to these bits leaves them unchanged. An error event in the same cycle as a clearing write leaves the flag set.
- R6: `ev_rx_overflow` clears receive-control bit 0 and sets the overflow flag, even if software writes the enable in the same cycle.
- R7: An increment and a decrement of the same counter in the same cycle leave the count unchanged, and the packet flag is set afterwards.
- R8: The counters wrap modulo 256: decrementing 0 gives 255, and incrementing 255 gives 0.
- R9: Interrupt status equals mask[7:0] AND {receive status[3:0], transmit status[3:0]}. Writes to index 4 have no effect.
- R10: `irq` is a register. It is high exactly when the interrupt status was nonzero in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tx_sent | input | 1 | Transmit engine finished a packet |
| ev_tx_underrun | input | 1 | Transmit engine ran out of descriptors |
| ev_rx_rcvd | input | 1 | Receive engine stored a packet |
| ev_rx_overflow | input | 1 | Receive engine found no empty descriptor |
| addr | input | 3 | Word index for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| rx_dma_en | output | 1 | Receive DMA enable |
| irq | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach is a collision on one counter. A hardware packet pulse and a software acknowledge must land on the same clock edge, but an ordinary register write cannot be placed against an event. The bench handles this with a dedicated task. It raises `ev_rx_rcvd` together with the write strobe on one negative edge, so both reach the same rising edge.

A second such case is the wrap below zero. Software has to acknowledge more packets than were counted. The bench does this after the flag has already cleared, and then checks that the count reads 255 while the flag stays low.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned CNT_LSB = 16;

  typedef enum logic [REG_AW-1:0] {
    IDX_TX_STAT  = 3'd0,
    IDX_RX_STAT  = 3'd1,
    IDX_RX_CTRL  = 3'd2,
    IDX_IRQ_MASK = 3'd3,
    IDX_IRQ_STAT = 3'd4
  } reg_idx_e;

  // Interrupt source byte: receive nibble high, transmit nibble low.
  function automatic logic [7:0] isr_merge(input logic [3:0] rx_nib,
                                           input logic [3:0] tx_nib,
                                           input logic [7:0] mask);
    return mask & {rx_nib, tx_nib};
  endfunction
endpackage

// File: rtl/dma_pkt_counter.sv
module dma_pkt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  // Next count for one hardware increment and/or one software decrement.
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c,
                                                input logic up, input logic dn);
    if (up && !dn) return c + 1'b1;
    if (dn && !up) return c - 1'b1;
    return c;
  endfunction

  logic [CNT_W-1:0] cnt_nx;
  assign cnt_nx = cnt_step(cnt, inc, dec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      if (inc) flag <= 1'b1;
      else if (dec && cnt_nx == '0) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_sticky_flag.sv
module dma_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/dma_stat_irq_regs.sv
module dma_stat_irq_regs
  import dma_stat_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_tx_sent,
  input  logic              ev_tx_underrun,
  input  logic              ev_rx_rcvd,
  input  logic              ev_rx_overflow,
  input  logic [2:0]        addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_dma_en,
  output logic              irq
);
  localparam int unsigned MASK_W = 8;

  // Named write-side events, also used by the checker.
  logic tx_dec, rx_dec, und_clr, ovf_clr, ctrl_wr, mask_wr;
  assign tx_dec  = wr_en && addr == IDX_TX_STAT && wr_data[0];
  assign rx_dec  = wr_en && addr == IDX_RX_STAT && wr_data[0];
  assign und_clr = wr_en && addr == IDX_TX_STAT && wr_data[1];
  assign ovf_clr = wr_en && addr == IDX_RX_STAT && wr_data[2];
  assign ctrl_wr = wr_en && addr == IDX_RX_CTRL;
  assign mask_wr = wr_en && addr == IDX_IRQ_MASK;

  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic tx_sent_f, rx_rcvd_f, tx_und_f, rx_ovf_f;

  dma_pkt_counter #(.CNT_W(CNT_W)) u_tx_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ev_tx_sent), .dec(tx_dec),
    .cnt(tx_cnt), .flag(tx_sent_f));
  dma_pkt_counter #(.CNT_W(CNT_W)) u_rx_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ev_rx_rcvd), .dec(rx_dec),
    .cnt(rx_cnt), .flag(rx_rcvd_f));
  dma_sticky_flag u_und (
    .clk(clk), .rst_n(rst_n), .set(ev_tx_underrun), .clr(und_clr), .q(tx_und_f));
  dma_sticky_flag u_ovf (
    .clk(clk), .rst_n(rst_n), .set(ev_rx_overflow), .clr(ovf_clr), .q(rx_ovf_f));

  logic              rx_en_q;
  logic [MASK_W-1:0] mask_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      if (ev_rx_overflow) rx_en_q <= 1'b0;
      else if (ctrl_wr)   rx_en_q <= wr_data[0];
      if (mask_wr) mask_q <= wr_data[MASK_W-1:0];
    end
  end
  assign rx_dma_en = rx_en_q;

  logic [3:0] tx_nib, rx_nib;
  assign tx_nib = {2'b00, tx_und_f, tx_sent_f};
  assign rx_nib = {1'b0, rx_ovf_f, 1'b0, rx_rcvd_f};

  logic [MASK_W-1:0] isr_vec;
  assign isr_vec = isr_merge(rx_nib, tx_nib, mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |isr_vec;
  end

  logic [DATA_W-1:0] tx_word, rx_word;
  always_comb begin
    tx_word = '0;
    tx_word[CNT_LSB +: CNT_W] = tx_cnt;
    tx_word[3:0] = tx_nib;
    rx_word = '0;
    rx_word[CNT_LSB +: CNT_W] = rx_cnt;
    rx_word[3:0] = rx_nib;
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      IDX_TX_STAT:  rd_data = tx_word;
      IDX_RX_STAT:  rd_data = rx_word;
      IDX_RX_CTRL:  rd_data[0] = rx_en_q;
      IDX_IRQ_MASK: rd_data[MASK_W-1:0] = mask_q;
      IDX_IRQ_STAT: rd_data[MASK_W-1:0] = isr_vec;
      default:      rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dma_stat_irq_chk.sv
module dma_stat_irq_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_tx_sent,
  input logic             ev_tx_underrun,
  input logic             ev_rx_overflow,
  input logic             tx_dec,
  input logic             und_clr,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             tx_sent_f,
  input logic             rx_rcvd_f,
  input logic             tx_und_f,
  input logic             rx_ovf_f,
  input logic             rx_dma_en,
  input logic [7:0]       isr_vec,
  input logic             irq
);
  AST_TX_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_sent && !tx_dec) |=> (tx_cnt == CNT_W'($past(tx_cnt) + 1'b1)) && tx_sent_f); // R3

  AST_FLAG_DROPS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_rcvd_f) |-> rx_cnt == '0); // R4

  AST_UNDERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (und_clr && !ev_tx_underrun) |=> !tx_und_f); // R5

  AST_OVERFLOW_STOPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_overflow |=> (!rx_dma_en && rx_ovf_f)); // R6

  AST_COLLIDE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_sent && tx_dec) |=> ($stable(tx_cnt) && tx_sent_f)); // R7

  AST_IRQ_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == ($past(isr_vec) != 8'h00))); // R10
endmodule

bind dma_stat_irq_regs dma_stat_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_tx_sent(ev_tx_sent),
  .ev_tx_underrun(ev_tx_underrun), .ev_rx_overflow(ev_rx_overflow),
  .tx_dec(tx_dec), .und_clr(und_clr), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_sent_f(tx_sent_f), .rx_rcvd_f(rx_rcvd_f), .tx_und_f(tx_und_f),
  .rx_ovf_f(rx_ovf_f), .rx_dma_en(rx_dma_en), .isr_vec(isr_vec), .irq(irq));

// File: tb/dma_stat_irq_regs_test.sv
module dma_stat_irq_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_tx_sent = 0, ev_tx_underrun = 0, ev_rx_rcvd = 0, ev_rx_overflow = 0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic rx_dma_en, irq;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dma_stat_irq_regs uut (
    .clk(clk), .rst_n(rst_n), .ev_tx_sent(ev_tx_sent),
    .ev_tx_underrun(ev_tx_underrun), .ev_rx_rcvd(ev_rx_rcvd),
    .ev_rx_overflow(ev_rx_overflow), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .rx_dma_en(rx_dma_en), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // code: bit0 tx_sent, bit1 tx_underrun, bit2 rx_rcvd, bit3 rx_overflow
  task automatic pulse(input logic [3:0] code);
    @(negedge clk);
    {ev_rx_overflow, ev_rx_rcvd, ev_tx_underrun, ev_tx_sent} = code;
    @(negedge clk);
    {ev_rx_overflow, ev_rx_rcvd, ev_tx_underrun, ev_tx_sent} = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), d); chk("R1 reset read", d, 32'h0);
    end
    chk("R1 rx_dma_en", {31'b0, rx_dma_en}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_count_and_ack();
    logic [31:0] d;
    do_reset();
    repeat (3) pulse(4'b0001);
    rd(3'd0, d); chk("R3 tx count 3", d, 32'h0003_0001);
    wr(3'd0, 32'h1);
    rd(3'd0, d); chk("R4 tx decrement keeps flag", d, 32'h0002_0001);
    wr(3'd0, 32'h1); wr(3'd0, 32'h1);
    rd(3'd0, d); chk("R4 flag clears at zero", d, 32'h0);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, d); chk("R2 unused index reads zero", d, 32'h0);
    rd(3'd1, d); chk("R2 rx untouched", d, 32'h0);
  endtask

  task automatic t_underrun();
    logic [31:0] d;
    do_reset();
    pulse(4'b0010);
    rd(3'd0, d); chk("R5 underrun set at bit1", d, 32'h2);
    wr(3'd0, 32'h0);
    rd(3'd0, d); chk("R5 zero write keeps underrun", d, 32'h2);
    wr(3'd0, 32'h2);
    rd(3'd0, d); chk("R5 underrun cleared", d, 32'h0);
    // clear and event together: flag stays
    @(negedge clk); addr = 3'd0; wr_data = 32'h2; wr_en = 1'b1; ev_tx_underrun = 1'b1;
    @(negedge clk); wr_en = 1'b0; ev_tx_underrun = 1'b0;
    rd(3'd0, d); chk("R5 event beats clear", d, 32'h2);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    do_reset();
    wr(3'd2, 32'h1);
    rd(3'd2, d); chk("R6 enable written", d, 32'h1);
    pulse(4'b1000);
    rd(3'd2, d); chk("R6 enable cleared", d, 32'h0);
    chk("R6 rx_dma_en low", {31'b0, rx_dma_en}, 32'h0);
    rd(3'd1, d); chk("R2 overflow at bit2", d, 32'h4);
    wr(3'd1, 32'h4);
    rd(3'd1, d); chk("R5 overflow cleared", d, 32'h0);
  endtask

  task automatic t_collide_wrap();
    logic [31:0] d;
    do_reset();
    pulse(4'b0100);
    @(negedge clk); addr = 3'd1; wr_data = 32'h1; wr_en = 1'b1; ev_rx_rcvd = 1'b1;
    @(negedge clk); wr_en = 1'b0; ev_rx_rcvd = 1'b0;
    rd(3'd1, d); chk("R7 collision holds count", d, 32'h0001_0001);
    wr(3'd1, 32'h1);
    rd(3'd1, d); chk("R4 rx flag cleared", d, 32'h0);
    wr(3'd1, 32'h1);
    rd(3'd1, d); chk("R8 wrap below zero", d, 32'h00FF_0000);
    pulse(4'b0100);
    rd(3'd1, d); chk("R8 wrap above 255", d, 32'h0000_0001);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    do_reset();
    wr(3'd3, 32'h10);
    pulse(4'b0001);
    rd(3'd4, d); chk("R9 masked tx source", d, 32'h0);
    @(negedge clk);
    chk("R10 irq low for masked", {31'b0, irq}, 32'h0);
    pulse(4'b0100);
    rd(3'd4, d); chk("R9 rx bit4 status", d, 32'h10);
    chk("R10 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 irq one cycle later", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'h0);
    rd(3'd4, d); chk("R9 status write ignored", d, 32'h10);
    wr(3'd3, 32'h03);
    rd(3'd4, d); chk("R9 tx nibble", d, 32'h01);
    chk("R10 irq still high", {31'b0, irq}, 32'h1);
    wr(3'd3, 32'h0);
    chk("R10 irq holds one cycle", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R10 irq drops", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_count_and_ack();
    t_underrun();
    t_overflow();
    t_collide_wrap();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule